// File: doc/BRIEF.md
# TDM Bus Timeslot Window Generator

This block sits beside an HDLC serial port on a framed time-division bus. It decides when the port's transmitter and receiver may move data, and it carries a one-byte control channel in a fixed timeslot.

It has two timing modes. In pin-driven mode, two enable inputs pass straight through to the port. In frame-derived mode, the block counts bits and slots from a frame pulse and opens both windows for one selected slot. The clock may run at the bit rate or at twice the bit rate.

In frame-derived mode the block can drive a control byte, MSB first, during slot 1, with an output-enable for a tri-state pad. In the same mode it captures the byte that arrives in slot 1 of every frame, whether or not its own driver is enabled.

Top module: `tdm_slot_timer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the bit/slot position is slot 0, bit 0. `cc_rx_byte_o` is 0 and `cc_oe_o` is 0.
- R2: When `int_mode_i` is 0, `tx_en_o` equals `ext_tx_en_i` and `rx_en_o` equals `ext_rx_en_i` in the same cycle, whatever the frame pulse does.
- R3: When `int_mode_i` is 1, `ext_tx_en_i` and `ext_rx_en_i` have no effect on any output.
- R4: A clock edge that samples `frame_pulse_i` high puts the position at slot 0, bit 0 for the next cycle, even in the middle of a frame.
- R5: With `bit_clk_sel_i` = 1, each bit lasts one clock. With `bit_clk_sel_i` = 0, each bit lasts two clocks. A frame has 32 slots of 8 bits, so it lasts 256 or 512 clocks.
- R6: In frame-derived mode, `tx_en_o` and `rx_en_o` are both high for the whole of slot N, where N is the 4-bit value of `slot_sel_i`. They are low in every other slot, so slots 16 to 31 are never selected.
- R7: In frame-derived mode with `cc_en_i` = 1, during slot 1 `cc_oe_o` is 1 and `cc_data_o` carries `cc_tx_byte_i`, bit 7 first. Bit k of the slot (k = 0..7) carries byte bit 7-k.
- R8: `cc_oe_o` is 0 in every slot other than slot 1, and in slot 1 whenever `cc_en_i` is 0. While `cc_oe_o` is 0, `cc_data_o` is 0.
- R9: When `int_mode_i` is 0, `cc_en_i` has no effect: `cc_oe_o` stays 0.
- R10: In frame-derived mode, `cc_rx_i` is sampled on the last clock of each bit of slot 1, in MSB-first order. `cc_rx_byte_o` takes the assembled byte at the clock edge that ends slot 1, whatever `cc_en_i` holds, and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, at 1x or 2x the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse_i | input | 1 | Frame start marker, one clock wide |
| ext_tx_en_i | input | 1 | Transmit enable used in pin-driven mode |
| ext_rx_en_i | input | 1 | Receive enable used in pin-driven mode |
| int_mode_i | input | 1 | 1 = frame-derived timing, 0 = pin-driven |
| bit_clk_sel_i | input | 1 | 1 = clock at bit rate, 0 = clock at twice the bit rate |
| cc_en_i | input | 1 | Drive the control byte in slot 1 |
| slot_sel_i | input | 4 | Slot that opens the transmit and receive windows |
| cc_tx_byte_i | input | 8 | Control byte to send |
| cc_rx_i | input | 1 | Serial input carrying the incoming control byte |
| tx_en_o | output | 1 | Transmit window |
| rx_en_o | output | 1 | Receive window |
| cc_data_o | output | 1 | Serial control-channel output data |
| cc_oe_o | output | 1 | Output-enable for the control-channel pad |
| cc_rx_byte_o | output | 8 | Last control byte received in slot 1 |

## Verification
A wrong bit or slot count shows up as a window that opens at the wrong clock, or lasts the wrong number of clocks, within the same frame. A slip in the 2x phase doubles or halves each window within one slot. A wrong bit index shows up at once on `cc_data_o` as a permuted control byte. A wrong sample phase shows up in `cc_rx_byte_o` at the end of the next slot 1. The bench compares every output on every clock over full frames, for all sixteen slot selections at both clock rates. From these frames a fault is visible no later than one frame after it occurs.

// File: rtl/tdm_slot_pkg.sv
// Package: frame geometry shared by the timeslot window generator.
// Assumes a fixed frame of whole slots, each of whole bits.
package tdm_slot_pkg;
    localparam int SLOTS_PER_FRAME = 32;
    localparam int BITS_PER_SLOT   = 8;
    localparam int SLOT_W          = $clog2(SLOTS_PER_FRAME);
    localparam int BIT_W           = $clog2(BITS_PER_SLOT);

    // Current place inside the frame.
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
        logic              phase;   // second clock of a bit in 2x mode
    } tdm_pos_t;
endpackage

// File: rtl/tdm_pos_counter.sv
// Module: tdm_pos_counter
// Tracks slot, bit and clock phase within a frame.
// The frame pulse forces slot 0, bit 0 on the next cycle.
// Assumes bit_clk_sel_i may change only between frames.
module tdm_pos_counter
    import tdm_slot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_pulse_i,
    input  logic     bit_clk_sel_i,
    output tdm_pos_t pos_o,
    output logic     bit_done_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_FRAME - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS_PER_SLOT - 1);

    tdm_pos_t pos_q;

    // Last clock of the current bit: every clock at 1x, odd phase at 2x.
    always_comb bit_done_o = bit_clk_sel_i || pos_q.phase;

    // Advance the phase, bit and slot; restart on the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (frame_pulse_i) begin
            pos_q <= '0;
        end else if (bit_done_o) begin
            pos_q.phase <= 1'b0;
            if (pos_q.bitn == LAST_BIT) begin
                pos_q.bitn <= '0;
                pos_q.slot <= (pos_q.slot == LAST_SLOT) ? '0 : pos_q.slot + 1'b1;
            end else begin
                pos_q.bitn <= pos_q.bitn + 1'b1;
            end
        end else begin
            pos_q.phase <= 1'b1;
        end
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/tdm_window_dec.sv
// Module: tdm_window_dec
// Picks the transmit/receive windows from the pins or from the slot
// count. Assumes the slot select is no wider than the slot count.
module tdm_window_dec
    import tdm_slot_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic              int_mode_i,
    input  logic              ext_tx_en_i,
    input  logic              ext_rx_en_i,
    input  logic [SEL_W-1:0]  slot_sel_i,
    input  logic [SLOT_W-1:0] cur_slot_i,
    output logic              tx_en_o,
    output logic              rx_en_o
);
    logic in_window;

    // Frame-derived window: the whole of the selected slot.
    always_comb in_window = (cur_slot_i == SLOT_W'(slot_sel_i));

    // Mode mux between pin enables and the slot window.
    always_comb begin
        if (int_mode_i) begin
            tx_en_o = in_window;
            rx_en_o = in_window;
        end else begin
            tx_en_o = ext_tx_en_i;
            rx_en_o = ext_rx_en_i;
        end
    end
endmodule

// File: rtl/tdm_cc_port.sv
// Module: tdm_cc_port
// Drives the control byte MSB first in the control slot and captures
// the incoming byte there every frame. Active only in frame-derived
// mode. Assumes the byte width equals the slot length in bits.
module tdm_cc_port
    import tdm_slot_pkg::*;
#(
    parameter int CC_SLOT = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     int_mode_i,
    input  logic                     cc_en_i,
    input  logic [SLOT_W-1:0]        cur_slot_i,
    input  logic [BIT_W-1:0]         cur_bit_i,
    input  logic                     bit_done_i,
    input  logic [BITS_PER_SLOT-1:0] cc_tx_byte_i,
    input  logic                     cc_rx_i,
    output logic                     cc_data_o,
    output logic                     cc_oe_o,
    output logic [BITS_PER_SLOT-1:0] cc_rx_byte_o
);
    localparam logic [SLOT_W-1:0] CC_SLOT_V = SLOT_W'(CC_SLOT);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS_PER_SLOT - 1);

    logic                     in_cc_slot;
    logic [BITS_PER_SLOT-1:0] shift_q;
    logic [BITS_PER_SLOT-1:0] shift_nx;
    logic                     sample_now;

    // The control slot is only recognised in frame-derived mode.
    always_comb in_cc_slot = int_mode_i && (cur_slot_i == CC_SLOT_V);

    // Output driver: MSB first, quiet and released outside the slot.
    always_comb begin
        cc_oe_o   = in_cc_slot && cc_en_i;
        cc_data_o = cc_oe_o ? cc_tx_byte_i[LAST_BIT - cur_bit_i] : 1'b0;
    end

    // Sample point and next shift value for the incoming byte.
    always_comb begin
        sample_now = in_cc_slot && bit_done_i;
        shift_nx   = {shift_q[BITS_PER_SLOT-2:0], cc_rx_i};
    end

    // Shift incoming bits; publish the byte after the slot's last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q      <= '0;
            cc_rx_byte_o <= '0;
        end else if (sample_now) begin
            shift_q <= shift_nx;
            if (cur_bit_i == LAST_BIT) begin
                cc_rx_byte_o <= shift_nx;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_timer.sv
// Module: tdm_slot_timer (top)
// Timeslot window generator for an HDLC port on a framed TDM bus.
// It chooses between pin enables and frame-derived slot windows, and
// carries a control byte in a fixed slot. Assumes the configuration
// inputs change only between frames.
module tdm_slot_timer
    import tdm_slot_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int CC_SLOT = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_pulse_i,
    input  logic                     ext_tx_en_i,
    input  logic                     ext_rx_en_i,
    input  logic                     int_mode_i,
    input  logic                     bit_clk_sel_i,
    input  logic                     cc_en_i,
    input  logic [SEL_W-1:0]         slot_sel_i,
    input  logic [BITS_PER_SLOT-1:0] cc_tx_byte_i,
    input  logic                     cc_rx_i,
    output logic                     tx_en_o,
    output logic                     rx_en_o,
    output logic                     cc_data_o,
    output logic                     cc_oe_o,
    output logic [BITS_PER_SLOT-1:0] cc_rx_byte_o
);
    tdm_pos_t          pos;
    logic              bit_done;
    logic [SLOT_W-1:0] cur_slot;
    logic [BIT_W-1:0]  cur_bit;

    // Split the position into the fields the consumers need.
    always_comb begin
        cur_slot = pos.slot;
        cur_bit  = pos.bitn;
    end

    tdm_pos_counter u_pos (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (frame_pulse_i),
        .bit_clk_sel_i (bit_clk_sel_i),
        .pos_o         (pos),
        .bit_done_o    (bit_done)
    );

    tdm_window_dec #(.SEL_W(SEL_W)) u_win (
        .int_mode_i  (int_mode_i),
        .ext_tx_en_i (ext_tx_en_i),
        .ext_rx_en_i (ext_rx_en_i),
        .slot_sel_i  (slot_sel_i),
        .cur_slot_i  (cur_slot),
        .tx_en_o     (tx_en_o),
        .rx_en_o     (rx_en_o)
    );

    tdm_cc_port #(.CC_SLOT(CC_SLOT)) u_cc (
        .clk          (clk),
        .rst_n        (rst_n),
        .int_mode_i   (int_mode_i),
        .cc_en_i      (cc_en_i),
        .cur_slot_i   (cur_slot),
        .cur_bit_i    (cur_bit),
        .bit_done_i   (bit_done),
        .cc_tx_byte_i (cc_tx_byte_i),
        .cc_rx_i      (cc_rx_i),
        .cc_data_o    (cc_data_o),
        .cc_oe_o      (cc_oe_o),
        .cc_rx_byte_o (cc_rx_byte_o)
    );
endmodule

// File: rtl/tdm_slot_timer_chk.sv
// Module: tdm_slot_timer_chk
// Assertions for tdm_slot_timer, attached with bind below.
module tdm_slot_timer_chk
    import tdm_slot_pkg::*;
#(
    parameter int CC_SLOT = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     frame_pulse_i,
    input logic                     bit_clk_sel_i,
    input logic                     int_mode_i,
    input logic                     cc_en_i,
    input logic                     tx_en_o,
    input logic                     rx_en_o,
    input logic                     cc_data_o,
    input logic                     cc_oe_o,
    input logic [BITS_PER_SLOT-1:0] cc_rx_byte_o,
    input logic [SLOT_W-1:0]        cur_slot,
    input logic [BIT_W-1:0]         cur_bit
);
    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse_i |=> (cur_slot == '0 && cur_bit == '0)); // R4

    AST_BIT_RATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse_i && bit_clk_sel_i) |=> (cur_bit == BIT_W'($past(cur_bit) + 1'b1))); // R5

    AST_WINDOWS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode_i |-> (tx_en_o == rx_en_o)); // R6

    AST_OE_ONLY_CC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        cc_oe_o |-> (cur_slot == SLOT_W'(CC_SLOT) && cc_en_i)); // R8

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_oe_o |-> !cc_data_o); // R8

    AST_EXT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !int_mode_i |-> !cc_oe_o); // R9

    AST_RX_BYTE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_rx_byte_o != $past(cc_rx_byte_o)) |-> ($past(cur_slot) == SLOT_W'(CC_SLOT))); // R10
endmodule

bind tdm_slot_timer tdm_slot_timer_chk #(.CC_SLOT(CC_SLOT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_pulse_i (frame_pulse_i),
    .bit_clk_sel_i (bit_clk_sel_i),
    .int_mode_i    (int_mode_i),
    .cc_en_i       (cc_en_i),
    .tx_en_o       (tx_en_o),
    .rx_en_o       (rx_en_o),
    .cc_data_o     (cc_data_o),
    .cc_oe_o       (cc_oe_o),
    .cc_rx_byte_o  (cc_rx_byte_o),
    .cur_slot      (cur_slot),
    .cur_bit       (cur_bit)
);

// File: tb/tdm_slot_timer_tb.sv
// Bench for tdm_slot_timer. It sweeps every slot selection at both
// clock rates and checks every output on every clock against values
// worked out from the frame arithmetic.
module tdm_slot_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_pulse_i;
    logic       ext_tx_en_i;
    logic       ext_rx_en_i;
    logic       int_mode_i;
    logic       bit_clk_sel_i;
    logic       cc_en_i;
    logic [3:0] slot_sel_i;
    logic [7:0] cc_tx_byte_i;
    logic       cc_rx_i;
    logic       tx_en_o;
    logic       rx_en_o;
    logic       cc_data_o;
    logic       cc_oe_o;
    logic [7:0] cc_rx_byte_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    tdm_slot_timer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (frame_pulse_i),
        .ext_tx_en_i   (ext_tx_en_i),
        .ext_rx_en_i   (ext_rx_en_i),
        .int_mode_i    (int_mode_i),
        .bit_clk_sel_i (bit_clk_sel_i),
        .cc_en_i       (cc_en_i),
        .slot_sel_i    (slot_sel_i),
        .cc_tx_byte_i  (cc_tx_byte_i),
        .cc_rx_i       (cc_rx_i),
        .tx_en_o       (tx_en_o),
        .rx_en_o       (rx_en_o),
        .cc_data_o     (cc_data_o),
        .cc_oe_o       (cc_oe_o),
        .cc_rx_byte_o  (cc_rx_byte_o)
    );

    // Compare one value; count it and report a mismatch.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Start a frame with a pulse, then check ncyc clocks of it.
    // The pulse edge gives t = 0 = slot 0, bit 0.
    task automatic run_frame(input logic bclk, input logic [3:0] sel, input logic ccen,
                             input logic [7:0] txb, input logic [7:0] rxb, input int ncyc);
        int per_bit;
        per_bit       = bclk ? 1 : 2;
        int_mode_i    = 1'b1;
        bit_clk_sel_i = bclk;
        slot_sel_i    = sel;
        cc_en_i       = ccen;
        cc_tx_byte_i  = txb;
        frame_pulse_i = 1'b1;
        @(negedge clk);
        frame_pulse_i = 1'b0;
        for (int t = 0; t < ncyc; t++) begin
            int slot;
            int bitn;
            logic win;
            logic oe;
            slot = (t / (8 * per_bit)) % 32;
            bitn = (t / per_bit) % 8;
            // Toggle the pin enables to show they are ignored (R3).
            ext_tx_en_i = t[0];
            ext_rx_en_i = ~t[1];
            cc_rx_i     = rxb[7 - bitn];
            #1;
            win = (slot == int'(sel));
            oe  = (slot == 1) && ccen;
            chk("R6/R3/R5 tx window", tx_en_o, win);
            chk("R6/R3/R5 rx window", rx_en_o, win);
            chk("R7/R8 cc_oe", cc_oe_o, oe);
            chk("R7/R8 cc_data", cc_data_o, oe ? txb[7 - bitn] : 1'b0);
            if (slot >= 2 && ncyc == 256 * per_bit)
                chk("R10 rx byte", cc_rx_byte_o, rxb);
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n         = 1'b0;
        frame_pulse_i = 1'b0;
        ext_tx_en_i   = 1'b0;
        ext_rx_en_i   = 1'b0;
        int_mode_i    = 1'b1;
        bit_clk_sel_i = 1'b1;
        cc_en_i       = 1'b1;
        slot_sel_i    = 4'd0;
        cc_tx_byte_i  = 8'hA5;
        cc_rx_i       = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset holds slot 0, bit 0 with nothing received.
        chk("R1 rx byte in reset", cc_rx_byte_o, 8'h00);
        chk("R1 window slot 0 in reset", tx_en_o, 1'b1);
        chk("R1 oe in reset", cc_oe_o, 1'b0);
        rst_n = 1'b1;
        #1;
        chk("R1 window after reset", tx_en_o, 1'b1);
        chk("R1 rx byte after reset", cc_rx_byte_o, 8'h00);
        @(negedge clk);

        // R4: a pulse cuts a frame short; the next frame is checked whole.
        run_frame(1'b1, 4'd3, 1'b1, 8'h3C, 8'h5A, 100);
        run_frame(1'b1, 4'd0, 1'b1, 8'h96, 8'hC3, 256);
        run_frame(1'b0, 4'd2, 1'b0, 8'h81, 8'h7E, 300);
        run_frame(1'b0, 4'd1, 1'b1, 8'h81, 8'h18, 512);

        // R5/R6/R7/R10: every slot selection at both clock rates.
        for (int r = 0; r < 2; r++) begin
            for (int s = 0; s < 16; s++) begin
                logic [7:0] tb_tx;
                logic [7:0] tb_rx;
                tb_tx = 8'(s * 37 + r * 11 + 5);
                tb_rx = 8'(s * 91 + r * 29 + 3);
                run_frame(r == 0, 4'(s), s[0], tb_tx, tb_rx, r == 0 ? 256 : 512);
            end
        end

        // R2/R9: pin-driven mode passes the pins through and never drives.
        int_mode_i = 1'b0;
        cc_en_i    = 1'b1;
        for (int i = 0; i < 600; i++) begin
            ext_tx_en_i   = (i % 3) == 0;
            ext_rx_en_i   = (i % 5) < 2;
            frame_pulse_i = (i % 97) == 0;
            #1;
            chk("R2 tx pass", tx_en_o, (i % 3) == 0);
            chk("R2 rx pass", rx_en_o, (i % 5) < 2);
            chk("R9 oe off in pin mode", cc_oe_o, 1'b0);
            chk("R9 data quiet in pin mode", cc_data_o, 1'b0);
            @(negedge clk);
        end
        frame_pulse_i = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule